// File: doc/BRIEF.md
# Shared Register Transfer Bus

This block is the datapath core of a small accumulator machine. One 16-bit bus carries a word between any two storage elements in a single clock. A 3-bit source code picks what drives the bus. There are seven real sources: two 12-bit address registers, four 16-bit word registers and a 16-bit read latch in front of a synchronous word memory. The eighth code leaves the bus at zero. Every register has its own clear, load and increment strobes. All of them act on the rising clock edge. More than one register can capture the same bus word in one cycle.

The memory address comes straight from the address register and does not pass over the bus. A write stores the current bus word at that address. A read copies the addressed word into the read latch, which then drives the bus when selected. The accumulator does not load from the bus: its load value comes from a separate input, because the arithmetic unit is outside this block. An 8-bit output register takes the low byte of the bus and never drives the bus.

Top module: `rtb_top`

## Requirements
- R1: The bus value follows the source code: 0 gives zero, 1 gives the address register, 2 gives the program counter, 3 gives the data register, 4 gives the accumulator, 5 gives the instruction register, 6 gives the temporary register, 7 gives the memory read latch. The 12-bit sources appear zero-extended, so bits 15:12 read as zero.
- R2: A register captures its input only on an edge where its load strobe is high. A register with no strobe high keeps its value.
- R3: The control field of each register is {clear, load, increment} in bits 2, 1 and 0. Clear wins over load, and load wins over increment.
- R4: Increment adds one modulo 2^width. The 12-bit program counter wraps from 0xFFF to 0x000.
- R5: When a 12-bit register loads from the bus, it keeps only the low 12 bits of the bus word.
- R6: On a load, the accumulator takes the value on its dedicated data input, not the bus value.
- R7: On an edge where the write strobe is high, memory stores the current bus word at the address held in the address register. Each address holds its own word.
- R8: The read latch changes only on an edge where the read strobe is high, and then takes the word at the current address. The read and write strobes are never high together.
- R9: On an edge where its load strobe is high, the output register captures bus bits 7:0. Otherwise it holds its value.
- R10: Synchronous active-high reset clears every register and the read latch to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 3 | Bus source code |
| ar_ctl | input | 3 | Address register {clear, load, increment} |
| pc_ctl | input | 3 | Program counter {clear, load, increment} |
| dr_ctl | input | 3 | Data register {clear, load, increment} |
| ac_ctl | input | 3 | Accumulator {clear, load, increment} |
| ir_ctl | input | 3 | Instruction register {clear, load, increment} |
| tr_ctl | input | 3 | Temporary register {clear, load, increment} |
| out_ld | input | 1 | Output register load strobe |
| mem_rd | input | 1 | Memory read strobe, fills the read latch |
| mem_wr | input | 1 | Memory write strobe, stores the bus word |
| ac_din | input | 16 | Accumulator load value |
| bus_q | output | 16 | Current bus value |
| ar_q | output | 12 | Address register |
| pc_q | output | 12 | Program counter |
| dr_q | output | 16 | Data register |
| ac_q | output | 16 | Accumulator |
| ir_q | output | 16 | Instruction register |
| tr_q | output | 16 | Temporary register |
| out_q | output | 8 | Output register |

## Verification
The bench loads every source with a distinct word and then walks all eight source codes. A swapped mux leg or a missing zero-extension of an address register therefore shows up as a wrong bus word. It sets clear, load and increment together and in pairs; a design with the priority reversed would leave the program counter at a loaded or incremented value instead of zero. The program counter is driven across 0xFFF to catch a counter that carries into bits the bus then exposes. The bench also writes memory without a read strobe, to catch a read latch that follows the array instead of holding. It drives the accumulator input and the bus with different values, to catch an accumulator that loads from the bus.

// File: rtl/rtb_pkg.sv
package rtb_pkg;

    localparam int WORD_W = 16;
    localparam int ADDR_W = 12;
    localparam int CHAR_W = 8;
    localparam int SEL_W  = 3;

    typedef enum logic [SEL_W-1:0] {
        SRC_NONE = 3'd0,
        SRC_AR   = 3'd1,
        SRC_PC   = 3'd2,
        SRC_DR   = 3'd3,
        SRC_AC   = 3'd4,
        SRC_IR   = 3'd5,
        SRC_TR   = 3'd6,
        SRC_MEM  = 3'd7
    } bus_src_e;

    typedef struct packed {
        logic clr;
        logic ld;
        logic inc;
    } reg_ctl_t;

    localparam reg_ctl_t CTL_IDLE = '{clr: 1'b0, ld: 1'b0, inc: 1'b0};

    function automatic logic [WORD_W-1:0] widen_addr(input logic [ADDR_W-1:0] a);
        return {{(WORD_W-ADDR_W){1'b0}}, a};
    endfunction

endpackage

// File: rtl/rtb_reg.sv
module rtb_reg
    import rtb_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  reg_ctl_t         ctl,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    always_ff @(posedge clk) begin
        if (rst)          q <= '0;
        else if (ctl.clr) q <= '0;
        else if (ctl.ld)  q <= d;
        else if (ctl.inc) q <= q + ONE;
    end

    AST_CLR_FIRST: assert property (@(posedge clk) disable iff (rst)
        ctl.clr |=> (q == '0)); // R3

    AST_LOAD_TAKES_D: assert property (@(posedge clk) disable iff (rst)
        (ctl.ld && !ctl.clr) |=> (q == $past(d))); // R2

    AST_INC_STEP: assert property (@(posedge clk) disable iff (rst)
        (ctl.inc && !ctl.ld && !ctl.clr) |=> (q == $past(q) + ONE)); // R4

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!ctl.inc && !ctl.ld && !ctl.clr) |=> $stable(q)); // R2

endmodule

// File: rtl/rtb_mem.sv
module rtb_mem #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr) store[addr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (rd) rdata <= store[addr];
    end

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd |=> $stable(rdata)); // R8

endmodule

// File: rtl/rtb_bus_mux.sv
module rtb_bus_mux
    import rtb_pkg::*;
(
    input  bus_src_e          sel,
    input  logic [ADDR_W-1:0] ar,
    input  logic [ADDR_W-1:0] pc,
    input  logic [WORD_W-1:0] dr,
    input  logic [WORD_W-1:0] ac,
    input  logic [WORD_W-1:0] ir,
    input  logic [WORD_W-1:0] tr,
    input  logic [WORD_W-1:0] mem,
    output logic [WORD_W-1:0] bus
);

    always_comb begin
        unique case (sel)
            SRC_AR:  bus = widen_addr(ar);
            SRC_PC:  bus = widen_addr(pc);
            SRC_DR:  bus = dr;
            SRC_AC:  bus = ac;
            SRC_IR:  bus = ir;
            SRC_TR:  bus = tr;
            SRC_MEM: bus = mem;
            default: bus = '0;
        endcase
    end

endmodule

// File: rtl/rtb_top.sv
module rtb_top
    import rtb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  bus_sel,
    input  logic [2:0]        ar_ctl,
    input  logic [2:0]        pc_ctl,
    input  logic [2:0]        dr_ctl,
    input  logic [2:0]        ac_ctl,
    input  logic [2:0]        ir_ctl,
    input  logic [2:0]        tr_ctl,
    input  logic              out_ld,
    input  logic              mem_rd,
    input  logic              mem_wr,
    input  logic [WORD_W-1:0] ac_din,
    output logic [WORD_W-1:0] bus_q,
    output logic [ADDR_W-1:0] ar_q,
    output logic [ADDR_W-1:0] pc_q,
    output logic [WORD_W-1:0] dr_q,
    output logic [WORD_W-1:0] ac_q,
    output logic [WORD_W-1:0] ir_q,
    output logic [WORD_W-1:0] tr_q,
    output logic [CHAR_W-1:0] out_q
);

    logic [WORD_W-1:0] bus_w;
    logic [WORD_W-1:0] mem_rdata;
    reg_ctl_t          out_ctl;

    assign out_ctl = '{clr: 1'b0, ld: out_ld, inc: 1'b0};

    rtb_reg #(.WIDTH(ADDR_W)) u_ar (.clk(clk), .rst(rst), .ctl(reg_ctl_t'(ar_ctl)),
                                    .d(bus_w[ADDR_W-1:0]), .q(ar_q));
    rtb_reg #(.WIDTH(ADDR_W)) u_pc (.clk(clk), .rst(rst), .ctl(reg_ctl_t'(pc_ctl)),
                                    .d(bus_w[ADDR_W-1:0]), .q(pc_q));
    rtb_reg #(.WIDTH(WORD_W)) u_dr (.clk(clk), .rst(rst), .ctl(reg_ctl_t'(dr_ctl)),
                                    .d(bus_w), .q(dr_q));
    rtb_reg #(.WIDTH(WORD_W)) u_ac (.clk(clk), .rst(rst), .ctl(reg_ctl_t'(ac_ctl)),
                                    .d(ac_din), .q(ac_q));
    rtb_reg #(.WIDTH(WORD_W)) u_ir (.clk(clk), .rst(rst), .ctl(reg_ctl_t'(ir_ctl)),
                                    .d(bus_w), .q(ir_q));
    rtb_reg #(.WIDTH(WORD_W)) u_tr (.clk(clk), .rst(rst), .ctl(reg_ctl_t'(tr_ctl)),
                                    .d(bus_w), .q(tr_q));
    rtb_reg #(.WIDTH(CHAR_W)) u_out (.clk(clk), .rst(rst), .ctl(out_ctl),
                                     .d(bus_w[CHAR_W-1:0]), .q(out_q));

    rtb_mem #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) u_mem (
        .clk(clk), .rst(rst), .addr(ar_q), .wr(mem_wr), .wdata(bus_w),
        .rd(mem_rd), .rdata(mem_rdata)
    );

    rtb_bus_mux u_mux (
        .sel(bus_src_e'(bus_sel)), .ar(ar_q), .pc(pc_q), .dr(dr_q), .ac(ac_q),
        .ir(ir_q), .tr(tr_q), .mem(mem_rdata), .bus(bus_w)
    );

    assign bus_q = bus_w;

    AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr)); // R8

    AST_OUT_LOW_BYTE: assert property (@(posedge clk) disable iff (rst)
        out_ld |=> (out_q == $past(bus_w[CHAR_W-1:0]))); // R9

    AST_AC_FROM_PORT: assert property (@(posedge clk) disable iff (rst)
        (ac_ctl[1] && !ac_ctl[2]) |=> (ac_q == $past(ac_din))); // R6

    AST_ADDR_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_sel == SRC_AR || bus_sel == SRC_PC) |-> (bus_q[WORD_W-1:ADDR_W] == '0)); // R1

endmodule

// File: tb/tb_rtb_top.sv
module tb_rtb_top;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [2:0]  sel;
        logic [15:0] exp;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{sel: 3'd0, exp: 16'h0000},
        '{sel: 3'd1, exp: 16'h00F0},
        '{sel: 3'd2, exp: 16'h0ABC},
        '{sel: 3'd3, exp: 16'h7F5A},
        '{sel: 3'd4, exp: 16'hA5C3},
        '{sel: 3'd5, exp: 16'h1234},
        '{sel: 3'd6, exp: 16'hBEEF},
        '{sel: 3'd7, exp: 16'hA5C3}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bus_sel = '0;
    logic [2:0]  ar_ctl = '0, pc_ctl = '0, dr_ctl = '0, ac_ctl = '0, ir_ctl = '0, tr_ctl = '0;
    logic        out_ld = 1'b0, mem_rd = 1'b0, mem_wr = 1'b0;
    logic [15:0] ac_din = '0;
    logic [15:0] bus_q, dr_q, ac_q, ir_q, tr_q;
    logic [11:0] ar_q, pc_q;
    logic [7:0]  out_q;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtb_top dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel),
        .ar_ctl(ar_ctl), .pc_ctl(pc_ctl), .dr_ctl(dr_ctl), .ac_ctl(ac_ctl),
        .ir_ctl(ir_ctl), .tr_ctl(tr_ctl), .out_ld(out_ld), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .ac_din(ac_din), .bus_q(bus_q), .ar_q(ar_q), .pc_q(pc_q),
        .dr_q(dr_q), .ac_q(ac_q), .ir_q(ir_q), .tr_q(tr_q), .out_q(out_q)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        ar_ctl = '0; pc_ctl = '0; dr_ctl = '0; ac_ctl = '0; ir_ctl = '0; tr_ctl = '0;
        out_ld = 1'b0; mem_rd = 1'b0; mem_wr = 1'b0;
    endtask

    // load v into AC, then move it over the bus into target 0=AR 1=PC 2=DR 3=IR 4=TR
    task automatic via_ac(input logic [15:0] v, input int dst);
        idle();
        ac_ctl = 3'b010; ac_din = v;
        tick();
        idle();
        bus_sel = 3'd4;
        case (dst)
            0: ar_ctl = 3'b010;
            1: pc_ctl = 3'b010;
            2: dr_ctl = 3'b010;
            3: ir_ctl = 3'b010;
            default: tr_ctl = 3'b010;
        endcase
        tick();
        idle();
    endtask

    task automatic all_zero(input string req);
        chk(req, {4'h0, ar_q}, 16'h0);
        chk(req, {4'h0, pc_q}, 16'h0);
        chk(req, dr_q, 16'h0);
        chk(req, ac_q, 16'h0);
        chk(req, ir_q, 16'h0);
        chk(req, tr_q, 16'h0);
        chk(req, {8'h0, out_q}, 16'h0);
        bus_sel = 3'd7; #1;
        chk(req, bus_q, 16'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle();
        tick(); tick();
        rst = 1'b0;
        all_zero("R10 reset");

        // fill sources
        via_ac(16'hF0F0, 0);
        chk("R5 AR low 12", {4'h0, ar_q}, 16'h00F0);
        via_ac(16'h9ABC, 1);
        chk("R5 PC low 12", {4'h0, pc_q}, 16'h0ABC);
        via_ac(16'h1234, 3);
        via_ac(16'hBEEF, 4);
        via_ac(16'h7F5A, 2);
        idle(); ac_ctl = 3'b010; ac_din = 16'hA5C3; tick(); idle();
        bus_sel = 3'd4; mem_wr = 1'b1; tick(); idle();
        mem_rd = 1'b1; tick(); idle();

        // source table walk
        foreach (VECS[i]) begin
            bus_sel = VECS[i].sel;
            #1;
            chk("R1 source select", bus_q, VECS[i].exp);
        end

        // priority on the program counter, DR drives 0x7F5A
        bus_sel = 3'd3; pc_ctl = 3'b111; tick(); idle();
        chk("R3 clear over load/inc", {4'h0, pc_q}, 16'h0000);
        bus_sel = 3'd3; pc_ctl = 3'b011; tick(); idle();
        chk("R3 load over inc", {4'h0, pc_q}, 16'h0F5A);
        pc_ctl = 3'b001; tick(); idle();
        chk("R4 increment", {4'h0, pc_q}, 16'h0F5B);
        chk("R2 IR holds", ir_q, 16'h1234);
        chk("R2 TR holds", tr_q, 16'hBEEF);
        chk("R2 AR holds", {4'h0, ar_q}, 16'h00F0);

        // wrap
        via_ac(16'hFFFF, 1);
        chk("R5 PC from all ones", {4'h0, pc_q}, 16'h0FFF);
        pc_ctl = 3'b001; tick(); idle();
        chk("R4 PC wrap", {4'h0, pc_q}, 16'h0000);
        tr_ctl = 3'b001; tick(); idle();
        chk("R4 TR increment", tr_q, 16'hBEF0);

        // accumulator source
        bus_sel = 3'd6; ac_ctl = 3'b010; ac_din = 16'h0042; tick(); idle();
        chk("R6 AC from port", ac_q, 16'h0042);

        // output register
        bus_sel = 3'd6; out_ld = 1'b1; tick(); idle();
        chk("R9 out low byte", {8'h0, out_q}, 16'h00F0);
        bus_sel = 3'd3; tick();
        chk("R9 out holds", {8'h0, out_q}, 16'h00F0);

        // memory write without read
        bus_sel = 3'd4; mem_wr = 1'b1; tick(); idle();
        bus_sel = 3'd7; #1;
        chk("R8 latch holds without read", bus_q, 16'hA5C3);
        mem_rd = 1'b1; tick(); idle();
        chk("R7 write then read", bus_q, 16'h0042);

        // second address
        ar_ctl = 3'b001; tick(); idle();
        chk("R4 AR increment", {4'h0, ar_q}, 16'h00F1);
        ac_ctl = 3'b010; ac_din = 16'h5555; tick(); idle();
        bus_sel = 3'd4; mem_wr = 1'b1; tick(); idle();
        mem_rd = 1'b1; tick(); idle();
        bus_sel = 3'd7; #1;
        chk("R7 second address", bus_q, 16'h5555);
        via_ac(16'h00F0, 0);
        mem_rd = 1'b1; tick(); idle();
        bus_sel = 3'd7; #1;
        chk("R7 first address kept", bus_q, 16'h0042);

        // clear with load on accumulator
        ac_ctl = 3'b110; ac_din = 16'h7777; tick(); idle();
        chk("R3 AC clear over load", ac_q, 16'h0000);

        // reset mid run
        rst = 1'b1; tick(); rst = 1'b0;
        all_zero("R10 reset mid run");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule